// File: doc/BRIEF.md
# Dispatch Group Formation Checker

This block sits after instruction classification and packs a stream of instructions, one per cycle, into dispatch groups of up to five. For every instruction it accepts, it keeps a running budget of each resource class that the open group has used. It then decides whether the instruction fits into that group. If it does not fit, the open group is closed and the instruction opens the next group.

When the instruction conflicts with earlier work in the same group, the block reports a structural hazard and asks for a no-op. Two cases count as such a conflict: a branch through the count register after a write to that register, and a load flagged as overlapping an earlier store. The overlap test is done upstream and arrives as one bit.

Every accepted, non-pseudo instruction produces a registered result one cycle later: its slot index within its group, a group-end pulse, and a hazard code. A scheduler uses the hazard code to decide between closing the group and inserting a no-op. A basic-block-start strobe forces a fresh, empty group.

Top module: `dispatch_group_checker`

## Requirements
- R1: Class codes on `in_class` are 0 fixed-point, 1 load, 2 store, 3 floating-point, 4 condition-register, 5 vector-ALU, 6 vector-permute, 7 branch, 8..15 pseudo. An accepted non-pseudo instruction gives `out_valid`=1 on the next cycle, with `out_slot` equal to its position (0..4) in its group; slots count up by one per instruction in a group.
- R2: A group takes at most two fixed-point, two floating-point and two load/store instructions, where loads and stores draw on one shared budget. An instruction over its budget gets `out_hazard`=1 (group break) and `out_slot`=0 of a new group.
- R3: A group takes at most one condition-register, one vector-ALU and one vector-permute instruction. A second one gets `out_hazard`=1 and slot 0.
- R4: Only a branch may sit in slot 4. Any other instruction that arrives after four have been issued gets `out_hazard`=1 and slot 0.
- R5: A branch ends its group: it is reported with `out_end`=1, and the next non-pseudo instruction takes slot 0 with `out_hazard`=0.
- R6: A branch with `ctr_branch`=1, in a group that already holds an instruction with `ctr_write`=1, gets `out_hazard`=2 (insert no-op) and slot 0 of a new group. Without that earlier write there is no hazard.
- R7: Codes 8..15 are ignored: there is no output pulse, and no slot, budget, count-register flag or store record is used.
- R8: A load with `ld_overlap`=1, after a store in the same open group, gets `out_hazard`=2 and slot 0. `ld_overlap` has no effect on other classes, or when no store is in the group.
- R9: Opening a new group, whether by a break, a no-op hazard, a branch or `bb_start`, clears every budget, the count-register flag and the store record.
- R10: While `rst` is high, `in_ready` and `out_valid` are 0. `bb_start` opens an empty group, so an instruction presented in the same cycle takes slot 0 with `out_hazard`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bb_start | input | 1 | Basic-block start: force a new empty group |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block accepts instructions |
| in_class | input | 4 | Instruction class code |
| ctr_write | input | 1 | Instruction writes the count register |
| ctr_branch | input | 1 | Instruction branches through the count register |
| ld_overlap | input | 1 | Load overlaps an earlier store's address |
| out_valid | output | 1 | Result of an accepted real instruction |
| out_slot | output | 3 | Slot index within the group |
| out_end | output | 1 | Instruction closes its group |
| out_hazard | output | 2 | 0 none, 1 group break, 2 insert no-op |

## Verification
The bench attacks the edges of every budget. It sends the third fixed-point op, a load after a store when the two share one budget, and a fifth non-branch. A design that counts off by one would pack one instruction too many, or break one too early. It also places pseudo codes between real instructions: a design that let them consume slots would break groups early. It tests store and count-register records across group boundaries, where a design that failed to clear them on a new group would raise false no-op requests. Finally, it presents `bb_start` together with an instruction, where a design that handled the clear too late would report the instruction at a non-zero slot.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  typedef enum logic [3:0] {
    CLS_FXU    = 4'd0,
    CLS_LD     = 4'd1,
    CLS_ST     = 4'd2,
    CLS_FPU    = 4'd3,
    CLS_CR     = 4'd4,
    CLS_VALU   = 4'd5,
    CLS_VPERM  = 4'd6,
    CLS_BR     = 4'd7,
    CLS_PSEUDO = 4'd8
  } iclass_e;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_BREAK = 2'd1,
    HZ_NOOP  = 2'd2
  } hazard_e;

  localparam int NUM_RES = 6;
  localparam int RES_FXU   = 0;
  localparam int RES_LSU   = 1;
  localparam int RES_FPU   = 2;
  localparam int RES_CR    = 3;
  localparam int RES_VALU  = 4;
  localparam int RES_VPERM = 5;
endpackage

// File: rtl/dgc_budget.sv
module dgc_budget #(
  parameter int FXU_CAP = 2,
  parameter int FPU_CAP = 2,
  parameter int LSU_CAP = 2,
  parameter int ONE_CAP = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restart,
  input  logic                        take,
  input  logic                        close,
  input  logic [dgc_pkg::NUM_RES-1:0] sel,
  output logic                        full_o
);
  import dgc_pkg::*;

  localparam int CAPS [NUM_RES] = '{FXU_CAP, LSU_CAP, FPU_CAP, ONE_CAP, ONE_CAP, ONE_CAP};
  localparam int MAXC = (FXU_CAP > FPU_CAP) ?
                        ((FXU_CAP > LSU_CAP) ? FXU_CAP : LSU_CAP) :
                        ((FPU_CAP > LSU_CAP) ? FPU_CAP : LSU_CAP);
  localparam int MAXA = (MAXC > ONE_CAP) ? MAXC : ONE_CAP;
  localparam int CW   = $clog2(MAXA + 1);

  logic [NUM_RES-1:0] full_vec;

  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    logic [CW-1:0] used_q;
    logic [CW-1:0] base;

    assign full_vec[i] = (used_q >= CW'(CAPS[i]));
    assign base        = restart ? '0 : used_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        used_q <= '0;
      end else if (close) begin
        used_q <= '0;
      end else begin
        used_q <= base + CW'(take && sel[i]);
      end
    end

    // R2 / R3: a budget never exceeds its cap
    a_r2_cap_bound: assert property (@(posedge clk) disable iff (rst)
      used_q <= CW'(CAPS[i]));
  end

  assign full_o = |(full_vec & sel);
endmodule

// File: rtl/dgc_struct.sv
module dgc_struct (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic take,
  input  logic close,
  input  logic ctr_wr,
  input  logic ctr_br,
  input  logic is_ld,
  input  logic is_st,
  input  logic overlap,
  output logic conflict_o
);
  logic ctr_q;
  logic st_q;

  assign conflict_o = (ctr_q && ctr_br) || (is_ld && st_q && overlap);

  always_ff @(posedge clk) begin
    if (rst || close) begin
      ctr_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      ctr_q <= (ctr_q && !restart) || (take && ctr_wr);
      st_q  <= (st_q  && !restart) || (take && is_st);
    end
  end

  // R9: a new group with nothing accepted leaves no structural record
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    restart && !take |=> !ctr_q && !st_q);
endmodule

// File: rtl/dispatch_group_checker.sv
module dispatch_group_checker #(
  parameter int GROUP_SIZE = 5,
  parameter int FXU_CAP    = 2,
  parameter int FPU_CAP    = 2,
  parameter int LSU_CAP    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bb_start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [3:0] in_class,
  input  logic       ctr_write,
  input  logic       ctr_branch,
  input  logic       ld_overlap,
  output logic       out_valid,
  output logic [2:0] out_slot,
  output logic       out_end,
  output logic [1:0] out_hazard
);
  import dgc_pkg::*;

  localparam int SLOT_W = $clog2(GROUP_SIZE);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(GROUP_SIZE - 1);

  logic              rdy_q;
  logic [SLOT_W-1:0] issued_q;
  logic [SLOT_W-1:0] base_issued;
  logic              is_real, is_br, is_ld, is_st, take;
  logic [NUM_RES-1:0] sel;
  logic              res_full, struct_hit;
  logic              brk_res, brk_str, brk;
  logic              restart, close;

  logic              ov_q, end_q;
  logic [SLOT_W-1:0] slot_q;
  hazard_e           haz_q;

  assign is_real = (in_class < 4'(CLS_PSEUDO));
  assign is_br   = (in_class == 4'(CLS_BR));
  assign is_ld   = (in_class == 4'(CLS_LD));
  assign is_st   = (in_class == 4'(CLS_ST));
  assign take    = in_valid && rdy_q && is_real;

  always_comb begin
    sel = '0;
    case (in_class)
      4'(CLS_FXU):   sel[RES_FXU]   = 1'b1;
      4'(CLS_LD),
      4'(CLS_ST):    sel[RES_LSU]   = 1'b1;
      4'(CLS_FPU):   sel[RES_FPU]   = 1'b1;
      4'(CLS_CR):    sel[RES_CR]    = 1'b1;
      4'(CLS_VALU):  sel[RES_VALU]  = 1'b1;
      4'(CLS_VPERM): sel[RES_VPERM] = 1'b1;
      default:       sel = '0;
    endcase
  end

  // Hazards are judged against the open group unless bb_start empties it.
  assign brk_res = !bb_start && (res_full || (issued_q == LAST && !is_br));
  assign brk_str = !bb_start && struct_hit;
  assign brk     = brk_res || brk_str;
  assign restart = bb_start || (take && brk);
  assign close   = take && is_br;

  assign base_issued = restart ? '0 : issued_q;

  dgc_budget #(
    .FXU_CAP(FXU_CAP),
    .FPU_CAP(FPU_CAP),
    .LSU_CAP(LSU_CAP),
    .ONE_CAP(1)
  ) u_budget (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .take   (take),
    .close  (close),
    .sel    (sel),
    .full_o (res_full)
  );

  dgc_struct u_struct (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .take      (take),
    .close     (close),
    .ctr_wr    (ctr_write),
    .ctr_br    (ctr_branch),
    .is_ld     (is_ld),
    .is_st     (is_st),
    .overlap   (ld_overlap),
    .conflict_o(struct_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q    <= 1'b0;
      issued_q <= '0;
      ov_q     <= 1'b0;
      end_q    <= 1'b0;
      slot_q   <= '0;
      haz_q    <= HZ_NONE;
    end else begin
      rdy_q <= 1'b1;
      ov_q  <= take;
      if (take) begin
        slot_q   <= base_issued;
        end_q    <= is_br;
        haz_q    <= brk_str ? HZ_NOOP : (brk_res ? HZ_BREAK : HZ_NONE);
        issued_q <= is_br ? '0 : base_issued + 1'b1;
      end else begin
        end_q    <= 1'b0;
        haz_q    <= HZ_NONE;
        issued_q <= base_issued;
      end
    end
  end

  assign in_ready   = rdy_q;
  assign out_valid  = ov_q;
  assign out_slot   = 3'(slot_q);
  assign out_end    = end_q;
  assign out_hazard = haz_q;

  // R4: the last slot only ever holds a group-ending branch
  a_r4_last_slot_branch: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_slot == 3'(LAST) |-> out_end);

  // R5: after a group end, the next reported instruction opens a group
  a_r5_after_end: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_end |=> (out_valid |-> out_slot == 3'd0));

  // R6 / R8: any hazard places the instruction at slot 0
  a_r6_hazard_slot0: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hazard != 2'(HZ_NONE) |-> out_slot == 3'd0);

  // R7: pseudo instructions produce no result
  a_r7_pseudo_silent: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_class >= 4'(CLS_PSEUDO) |=> !out_valid);

  // R10: an instruction arriving with bb_start starts clean
  a_r10_bb_start: assert property (@(posedge clk) disable iff (rst)
    bb_start && in_valid && in_ready && in_class < 4'(CLS_PSEUDO)
    |=> out_valid && out_slot == 3'd0 && out_hazard == 2'(HZ_NONE));
endmodule

// File: tb/dispatch_group_checker_tb.sv
`timescale 1ns/1ps
module dispatch_group_checker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bb_start = 1'b0, in_valid = 1'b0;
  logic [3:0] in_class = 4'd8;
  logic       ctr_write = 1'b0, ctr_branch = 1'b0, ld_overlap = 1'b0;
  logic       in_ready, out_valid, out_end;
  logic [2:0] out_slot;
  logic [1:0] out_hazard;

  int checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference state
  int nfx, nfp, nls, issued;
  bit hcr, hva, hvp, hctr, hst;
  bit e_valid, e_end;
  int e_slot, e_haz;

  always #4 clk = ~clk;

  dispatch_group_checker u_dut (
    .clk(clk), .rst(rst), .bb_start(bb_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_class(in_class), .ctr_write(ctr_write),
    .ctr_branch(ctr_branch), .ld_overlap(ld_overlap), .out_valid(out_valid),
    .out_slot(out_slot), .out_end(out_end), .out_hazard(out_hazard));

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic empty_group();
    nfx = 0; nfp = 0; nls = 0; issued = 0;
    hcr = 0; hva = 0; hvp = 0; hctr = 0; hst = 0;
  endtask

  task automatic compare();
    check(tag, int'(out_valid), int'(e_valid), "out_valid");
    if (e_valid) begin
      check(tag, int'(out_slot), e_slot, "out_slot");
      check(tag, int'(out_hazard), e_haz, "out_hazard");
      check(tag, int'(out_end), int'(e_end), "out_end");
    end
  endtask

  // one clock: compare previous result, drive new inputs, predict
  task automatic cyc(int c, bit v = 1, bit cw = 0, bit cb = 0, bit ov = 0, bit bb = 0);
    bit full, res, str;
    @(negedge clk);
    compare();
    in_class = 4'(c); in_valid = v; ctr_write = cw; ctr_branch = cb;
    ld_overlap = ov; bb_start = bb;
    if (bb) empty_group();
    e_valid = 0;
    if (v && c < 8) begin
      case (c)
        0: full = (nfx >= 2);
        1, 2: full = (nls >= 2);
        3: full = (nfp >= 2);
        4: full = hcr;
        5: full = hva;
        6: full = hvp;
        default: full = 0;
      endcase
      res = full || (issued == 4 && c != 7);
      str = (hctr && cb) || (c == 1 && hst && ov);
      e_haz = str ? 2 : (res ? 1 : 0);
      if (res || str) empty_group();
      e_valid = 1; e_slot = issued; e_end = (c == 7);
      issued++;
      case (c)
        0: nfx++;
        1: nls++;
        2: begin nls++; hst = 1; end
        3: nfp++;
        4: hcr = 1;
        5: hva = 1;
        6: hvp = 1;
        default: ;
      endcase
      if (cw) hctr = 1;
      if (c == 7) empty_group();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    empty_group();
    e_valid = 0;
    repeat (3) @(negedge clk);
    tag = "R10";
    check("R10", int'(in_ready), 0, "in_ready in reset");
    check("R10", int'(out_valid), 0, "out_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R10", int'(in_ready), 1, "in_ready after reset");

    tag = "R1";  cyc(0); cyc(3); cyc(1); cyc(4);
    tag = "R5";  cyc(7); cyc(0);
    tag = "R2";  cyc(0); cyc(0); cyc(7);
    cyc(1); cyc(2); cyc(1); cyc(7);
    cyc(3); cyc(3); cyc(3); cyc(7);
    tag = "R3";  cyc(4); cyc(4); cyc(5); cyc(5); cyc(6); cyc(6); cyc(7);
    tag = "R4";  cyc(0); cyc(3); cyc(1); cyc(4); cyc(5);
    cyc(7); cyc(0); cyc(3); cyc(1); cyc(4); cyc(7); cyc(0);
    tag = "R6";  cyc(7); cyc(0, 1, 1); cyc(7, 1, 0, 1);
    cyc(0); cyc(7, 1, 0, 1);
    tag = "R7";  cyc(7); cyc(0); cyc(8); cyc(15); cyc(0); cyc(12); cyc(0);
    cyc(9, 1, 1); cyc(7, 1, 0, 1);
    tag = "R8";  cyc(2); cyc(1, 1, 0, 0, 1); cyc(7);
    cyc(1, 1, 0, 0, 1); cyc(0, 1, 0, 0, 1); cyc(7);
    tag = "R9";  cyc(2); cyc(2); cyc(1, 1, 0, 0, 1); cyc(0);
    cyc(0, 1, 1); cyc(0); cyc(0); cyc(7, 1, 0, 1); cyc(7);
    tag = "R10"; cyc(0); cyc(0); cyc(0, 1, 0, 0, 0, 1); cyc(2);
    cyc(8, 0, 0, 0, 0, 1); cyc(1, 1, 0, 0, 1);
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      cyc(k == 9 ? $urandom_range(8, 15) : k, $urandom_range(0, 9) < 8,
          $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 1) == 1, $urandom_range(0, 30) == 0);
    end
    cyc(8, 0);
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule